// File: doc/BRIEF.md
# Wake-up frame pattern filter bank

This block watches a received Ethernet frame one byte per beat, starting at the first byte of the destination address. It decides whether the frame should wake the system. Four filters run in parallel. Each filter has an enable, a unicast/multicast selector, an 8-bit start offset, a 31-bit byte-select mask and an expected CRC-16. For every beat, each filter decides whether that byte falls inside its window and is picked by its mask. Picked bytes go into the filter's own CRC register. On the last beat of a good frame, each enabled filter compares its accumulated CRC with its expected value.

A match raises a one-cycle wake pulse and sets a sticky per-filter status bit. A frame whose destination address is all ones also raises the wake pulse and sets a sticky broadcast status bit. This happens regardless of the filters and of the broadcast-disable control. Detection depends only on a global enable. The power-state input has no influence. A start strobe restarts the position counter and every CRC, so frames may follow each other with no idle beat.

Top module: `wake_pattern_bank`

## Requirements
- R1: After reset, `wake_o`, `match_o` and `bcast_hit_o` are all 0.
- R2: The sof beat is position 0 and each later valid beat adds one. The byte at position p is fed to filter i exactly when ofs_i <= p <= ofs_i+30 and mask bit (p - ofs_i) is set. Filter i's fields are `cfg_offset_i[8*i +: 8]`, `cfg_mask_i[31*i +: 31]` and `cfg_crc_i[16*i +: 16]`.
- R3: The CRC register is loaded with 0xFFFF on the sof beat. Each selected byte is shifted in LSB first using the right-shift form of polynomial 0x8005 (xor constant 0xA001). The final register value is compared unmodified with the expected field.
- R4: Command nibble `cfg_cmd_i[4*i +: 4]`: bit 0 enables filter i, and a disabled filter never matches. Bits 2:1 are ignored.
- R5: When command bit 3 is 1, the filter matches only frames whose first destination byte has bit 0 set. When bit 3 is 0, it matches only frames where that bit is clear.
- R6: Matches are evaluated only on a beat that has `valid_i`, `eof_i`, `frame_good_i` and `det_en_i` all high. `wake_o` is high for exactly the following cycle. A frame that ends before all masked bytes arrive compares the CRC it has accumulated.
- R7: `match_o[i]` is set by a filter i match and stays set until `status_clr_i`. A set in the same cycle as a clear wins.
- R8: When the first six bytes are 0xFF, an evaluated frame sets `bcast_hit_o` and pulses `wake_o`. This happens whatever the filters are and even with `bcast_block_i` high. A frame shorter than six bytes is not broadcast.
- R9: `pwr_state_i` has no effect on detection.
- R10: A sof beat directly after an eof beat restarts position and CRCs, so back-to-back frames are judged independently.
- R11: With `det_en_i` low at the end beat, no wake pulse and no status change occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| det_en_i | input | 1 | Global wake-frame detection enable |
| pwr_state_i | input | 2 | Current power state (no effect) |
| bcast_block_i | input | 1 | Receive broadcast-disable control (does not block wake) |
| valid_i | input | 1 | Byte beat valid |
| sof_i | input | 1 | First byte of frame (with valid_i) |
| eof_i | input | 1 | Last byte of frame (with valid_i) |
| data_i | input | 8 | Frame byte |
| frame_good_i | input | 1 | Frame received without error, sampled on the eof beat |
| cfg_mask_i | input | 124 | Four 31-bit byte-select masks |
| cfg_cmd_i | input | 16 | Four 4-bit command nibbles |
| cfg_offset_i | input | 32 | Four 8-bit start offsets |
| cfg_crc_i | input | 64 | Four expected CRC-16 values |
| status_clr_i | input | 1 | Clears sticky status |
| wake_o | output | 1 | One-cycle wake pulse |
| match_o | output | 4 | Sticky per-filter match status |
| bcast_hit_o | output | 1 | Sticky broadcast-wake status |

## Verification
The bench targets the window edges. It uses a mask reaching offset+30 in a long frame, where a design that kept feeding bytes past the window would compute the wrong CRC. It uses a frame shorter than the window, where a design that waited for every masked byte would never match. Frames sent back to back check that a missed CRC reload corrupts the second frame's result. Further stimulus covers a frame of four 0xFF bytes that must not count as broadcast, a broadcast with the broadcast-disable control high, command bits 2:1 set, bad-frame and disabled-detection end beats, and a status clear coinciding with a match. Each of these exposes a specific gating or priority error as a wrong status bit or a stray wake pulse.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int NUM_FILT_D = 4;
  localparam int MASK_W_D   = 31;
  localparam int OFS_W_D    = 8;
  localparam int CMD_W      = 4;
  localparam int CMD_EN_BIT = 0;
  localparam int CMD_MC_BIT = 3;
  localparam int CRC_W      = 16;
  localparam int DA_LEN     = 6;
  localparam logic [CRC_W-1:0] CRC_INIT = 16'hFFFF;
  localparam logic [CRC_W-1:0] CRC_XOR  = 16'hA001;  // 0x8005 reflected

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [7:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_XOR;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/wake_frame_track.sv
module wake_frame_track
  import wake_pkg::*;
#(
  parameter int POS_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic [7:0]       data_i,
  output logic [POS_W-1:0] pos_o,
  output logic             mcast_o,
  output logic             bcast_o
);
  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam logic [POS_W-1:0] DA_END  = POS_W'(DA_LEN);

  logic [POS_W-1:0] pos_q, pos_cur;
  logic             mc_q, bc_q, bc_base, bc_cur;

  assign pos_cur = sof_i ? '0 : pos_q;
  assign mcast_o = sof_i ? data_i[0] : mc_q;
  assign bc_base = sof_i ? 1'b1 : bc_q;
  assign bc_cur  = bc_base & ((pos_cur >= DA_END) | (data_i == 8'hFF));
  assign bcast_o = bc_cur & (pos_cur >= DA_END - 1'b1);
  assign pos_o   = pos_cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      mc_q  <= 1'b0;
      bc_q  <= 1'b0;
    end else if (valid_i) begin
      pos_q <= (pos_cur == POS_MAX) ? POS_MAX : pos_cur + 1'b1;
      mc_q  <= mcast_o;
      bc_q  <= bc_cur;
    end
  end

  assert_pos_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q < $past(pos_q)) |-> $past(valid_i && sof_i));
endmodule

// File: rtl/wake_filter_lane.sv
module wake_filter_lane
  import wake_pkg::*;
#(
  parameter int MASK_W = 31,
  parameter int OFS_W  = 8,
  parameter int POS_W  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sof_i,
  input  logic [7:0]        data_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              mcast_i,
  input  logic              en_i,
  input  logic              mc_sel_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [CRC_W-1:0]  exp_i,
  output logic              hit_o
);
  localparam int IDX_W = $clog2(MASK_W + 1);
  localparam logic [POS_W-1:0] LIM = POS_W'(MASK_W);

  logic [POS_W-1:0] ofs_ext, rel;
  logic             in_win, sel;
  logic [CRC_W-1:0] crc_q, crc_base, crc_nxt;

  assign ofs_ext  = POS_W'(ofs_i);
  assign rel      = pos_i - ofs_ext;
  assign in_win   = (pos_i >= ofs_ext) && (rel < LIM);
  assign sel      = valid_i && in_win && mask_i[rel[IDX_W-1:0]];
  assign crc_base = sof_i ? CRC_INIT : crc_q;
  assign crc_nxt  = sel ? crc_step(crc_base, data_i) : crc_base;
  assign hit_o    = en_i && (mc_sel_i == mcast_i) && (crc_nxt == exp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= CRC_INIT;
    else if (valid_i) crc_q <= crc_nxt;
  end

  // unselected start byte leaves the seed untouched
  assert_crc_seed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && sof_i && !sel) |-> (crc_q == CRC_INIT));
endmodule

// File: rtl/wake_pattern_bank.sv
module wake_pattern_bank
  import wake_pkg::*;
#(
  parameter int NUM_FILT = NUM_FILT_D,
  parameter int MASK_W   = MASK_W_D,
  parameter int OFS_W    = OFS_W_D
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      det_en_i,
  input  logic [1:0]                pwr_state_i,
  input  logic                      bcast_block_i,
  input  logic                      valid_i,
  input  logic                      sof_i,
  input  logic                      eof_i,
  input  logic [7:0]                data_i,
  input  logic                      frame_good_i,
  input  logic [NUM_FILT*MASK_W-1:0] cfg_mask_i,
  input  logic [NUM_FILT*CMD_W-1:0]  cfg_cmd_i,
  input  logic [NUM_FILT*OFS_W-1:0]  cfg_offset_i,
  input  logic [NUM_FILT*CRC_W-1:0]  cfg_crc_i,
  input  logic                      status_clr_i,
  output logic                      wake_o,
  output logic [NUM_FILT-1:0]       match_o,
  output logic                      bcast_hit_o
);
  localparam int POS_W = OFS_W + 1;

  logic [POS_W-1:0]    pos;
  logic                mcast, bcast;
  logic [NUM_FILT-1:0] hit_vec, filt_fire;
  logic [2*NUM_FILT-1:0] unused_cmd;
  logic                eval, bc_fire;
  logic                unused_inputs;

  // power state and broadcast-disable never gate wake detection
  assign unused_inputs = ^{pwr_state_i, bcast_block_i, unused_cmd};

  wake_frame_track #(.POS_W(POS_W)) u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .sof_i   (sof_i),
    .data_i  (data_i),
    .pos_o   (pos),
    .mcast_o (mcast),
    .bcast_o (bcast)
  );

  for (genvar i = 0; i < NUM_FILT; i++) begin : g_lane
    assign unused_cmd[2*i +: 2] = cfg_cmd_i[i*CMD_W + 1 +: 2];

    wake_filter_lane #(.MASK_W(MASK_W), .OFS_W(OFS_W), .POS_W(POS_W)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .valid_i  (valid_i),
      .sof_i    (sof_i),
      .data_i   (data_i),
      .pos_i    (pos),
      .mcast_i  (mcast),
      .en_i     (cfg_cmd_i[i*CMD_W + CMD_EN_BIT]),
      .mc_sel_i (cfg_cmd_i[i*CMD_W + CMD_MC_BIT]),
      .ofs_i    (cfg_offset_i[i*OFS_W +: OFS_W]),
      .mask_i   (cfg_mask_i[i*MASK_W +: MASK_W]),
      .exp_i    (cfg_crc_i[i*CRC_W +: CRC_W]),
      .hit_o    (hit_vec[i])
    );

    assert_off_no_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(match_o[i]) |-> $past(cfg_cmd_i[i*CMD_W + CMD_EN_BIT]));
  end

  assign eval      = valid_i && eof_i && frame_good_i && det_en_i;
  assign filt_fire = eval ? hit_vec : '0;
  assign bc_fire   = eval && bcast;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_o      <= 1'b0;
      match_o     <= '0;
      bcast_hit_o <= 1'b0;
    end else begin
      wake_o      <= (|filt_fire) | bc_fire;
      match_o     <= (status_clr_i ? '0 : match_o) | filt_fire;  // set beats clear
      bcast_hit_o <= (status_clr_i ? 1'b0 : bcast_hit_o) | bc_fire;
    end
  end

  assert_wake_at_eval_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(valid_i && eof_i && frame_good_i && det_en_i));

  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(match_o) & ~match_o)) |-> $past(status_clr_i));

  assert_bcast_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bcast_hit_o) |-> $past(det_en_i && frame_good_i && eof_i));

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(det_en_i) |-> !wake_o);
endmodule

// File: tb/sim_wake_pattern_bank.sv
module sim_wake_pattern_bank;
  localparam int NF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic det_en, bc_blk, valid, sof, eof, good, clr;
  logic [1:0] pwr;
  logic [7:0] data;
  logic [NF*31-1:0] cfg_mask;
  logic [NF*4-1:0]  cfg_cmd;
  logic [NF*8-1:0]  cfg_ofs;
  logic [NF*16-1:0] cfg_crc;
  logic wake, bch;
  logic [NF-1:0] match;

  logic [7:0]  b_ofs  [NF];
  logic [30:0] b_mask [NF];
  logic [3:0]  b_cmd  [NF];
  logic [15:0] b_crc  [NF];

  always_comb begin
    for (int i = 0; i < NF; i++) begin
      cfg_mask[i*31 +: 31] = b_mask[i];
      cfg_cmd[i*4 +: 4]    = b_cmd[i];
      cfg_ofs[i*8 +: 8]    = b_ofs[i];
      cfg_crc[i*16 +: 16]  = b_crc[i];
    end
  end

  wake_pattern_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .det_en_i(det_en), .pwr_state_i(pwr),
    .bcast_block_i(bc_blk), .valid_i(valid), .sof_i(sof), .eof_i(eof),
    .data_i(data), .frame_good_i(good), .cfg_mask_i(cfg_mask),
    .cfg_cmd_i(cfg_cmd), .cfg_offset_i(cfg_ofs), .cfg_crc_i(cfg_crc),
    .status_clr_i(clr), .wake_o(wake), .match_o(match), .bcast_hit_o(bch)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] frm [64];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // bench model: reflected CRC, bitwise
  function automatic logic [15:0] ref_crc(input int n, input int off, input logic [30:0] m);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int k = 0; k < n; k++) begin
      if (k >= off && k - off < 31 && m[k-off]) begin
        for (int b = 0; b < 8; b++) begin
          if ((c[0] ^ frm[k][b]) == 1'b1) c = (c >> 1) ^ 16'hA001;
          else c = c >> 1;
        end
      end
    end
    return c;
  endfunction

  // kind: 0 unicast, 1 multicast, 2 broadcast-style DA
  task automatic build(input logic [1:0] kind, input int n, input logic [7:0] seed);
    for (int k = 0; k < 64; k++) frm[k] = seed + 8'(k * 37);
    case (kind)
      2'd0: frm[0][0] = 1'b0;
      2'd1: begin frm[0][0] = 1'b1; frm[1] = 8'h5A; end
      default: for (int k = 0; k < 6; k++) if (k < n) frm[k] = 8'hFF;
    endcase
  endtask

  task automatic send(input int n, input logic g, input logic hold, input logic clr_last);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      valid = 1'b1; sof = (k == 0); eof = (k == n - 1); data = frm[k];
      good = (k == n - 1) ? g : 1'b0;
      clr  = clr_last && (k == n - 1);
    end
    if (!hold) begin
      @(negedge clk);
      valid = 1'b0; sof = 1'b0; eof = 1'b0; good = 1'b0; clr = 1'b0;
    end
  endtask

  task automatic clear_status();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  typedef struct packed {
    logic [1:0]  kind;
    logic [6:0]  len;
    logic        good;
    logic        gen;
    logic [7:0]  off;
    logic [30:0] mask;
    logic [15:0] cmds;
    logic [3:0]  corr;
    logic [1:0]  pwr;
    logic        blk;
    logic [7:0]  seed;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 7'd20, 1'b1, 1'b1, 8'd0,  31'h0000_00F3, 16'h9011, 4'b1101, 2'd0, 1'b0, 8'h13},
    '{2'd1, 7'd40, 1'b1, 1'b1, 8'd2,  31'h7FFF_FFFF, 16'h91F9, 4'b1111, 2'd1, 1'b0, 8'h77},
    '{2'd2, 7'd30, 1'b1, 1'b1, 8'd0,  31'h0000_0FC0, 16'h9999, 4'b0101, 2'd0, 1'b1, 8'h31},
    '{2'd0, 7'd5,  1'b1, 1'b1, 8'd1,  31'h7FFF_FFFF, 16'h1111, 4'b1111, 2'd0, 1'b0, 8'h44},
    '{2'd0, 7'd20, 1'b0, 1'b1, 8'd0,  31'h0000_00F3, 16'h1111, 4'b1111, 2'd0, 1'b0, 8'h13},
    '{2'd0, 7'd20, 1'b1, 1'b0, 8'd0,  31'h0000_00F3, 16'h1111, 4'b1111, 2'd0, 1'b0, 8'h13},
    '{2'd2, 7'd4,  1'b1, 1'b1, 8'd0,  31'h0000_000F, 16'h0000, 4'b1111, 2'd0, 1'b0, 8'h05},
    '{2'd0, 7'd60, 1'b1, 1'b1, 8'd20, 31'h4000_0001, 16'h1111, 4'b1111, 2'd3, 1'b0, 8'h9C},
    '{2'd1, 7'd12, 1'b1, 1'b1, 8'd0,  31'h0000_2AAA, 16'h9999, 4'b1110, 2'd2, 1'b1, 8'hE1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] exp_m;
    logic exp_b;
    logic [15:0] crc_a, crc_b;
    det_en = 1'b1; bc_blk = 1'b0; pwr = 2'd0; valid = 1'b0; sof = 1'b0; eof = 1'b0;
    good = 1'b0; clr = 1'b0; data = 8'h00;
    for (int i = 0; i < NF; i++) begin
      b_ofs[i] = '0; b_mask[i] = '0; b_cmd[i] = '0; b_crc[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 wake", {31'd0, wake}, 32'd0);
    chk("R1 match", {28'd0, match}, 32'd0);
    chk("R1 bcast", {31'd0, bch}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {27'd0, wake, match}, 32'd0);

    // table: R2/R3/R4/R5 via per-filter match, R6/R11 gating, R8 broadcast, R9 pwr varied
    for (int v = 0; v < NV; v++) begin
      build(VECS[v].kind, int'(VECS[v].len), VECS[v].seed);
      exp_m = '0;
      for (int i = 0; i < NF; i++) begin
        b_ofs[i]  = VECS[v].off + 8'(3 * i);
        b_mask[i] = VECS[v].mask >> i;
        b_cmd[i]  = VECS[v].cmds[i*4 +: 4];
        crc_a     = ref_crc(int'(VECS[v].len), int'(b_ofs[i]), b_mask[i]);
        b_crc[i]  = VECS[v].corr[i] ? crc_a : crc_a ^ 16'h1234;
        exp_m[i]  = VECS[v].gen && VECS[v].good && b_cmd[i][0] &&
                    (b_cmd[i][3] == frm[0][0]) && VECS[v].corr[i];
      end
      exp_b = VECS[v].gen && VECS[v].good && (VECS[v].len >= 6) &&
              (frm[0] & frm[1] & frm[2] & frm[3] & frm[4] & frm[5]) == 8'hFF;
      pwr = VECS[v].pwr; bc_blk = VECS[v].blk; det_en = VECS[v].gen;
      clear_status();
      send(int'(VECS[v].len), VECS[v].good, 1'b0, 1'b0);
      chk($sformatf("R2/R3/R4/R5 match v%0d", v), {28'd0, match}, {28'd0, exp_m});
      chk($sformatf("R8 bcast v%0d", v), {31'd0, bch}, {31'd0, exp_b});
      chk($sformatf("R6/R11 wake v%0d", v), {31'd0, wake}, {31'd0, (|exp_m) | exp_b});
      @(negedge clk);
      chk($sformatf("R6 pulse width v%0d", v), {31'd0, wake}, 32'd0);
    end
    det_en = 1'b1; pwr = 2'd0; bc_blk = 1'b0;

    // R7 sticky status, clear, set beats clear
    build(2'd0, 16, 8'h03);
    for (int i = 0; i < NF; i++) begin
      b_ofs[i] = 8'd0; b_mask[i] = 31'h0000_FFFF; b_cmd[i] = 4'h0; b_crc[i] = 16'h0;
    end
    b_cmd[0] = 4'h1;
    b_crc[0] = ref_crc(16, 0, 31'h0000_FFFF);
    crc_a = b_crc[0];
    clear_status();
    send(16, 1'b1, 1'b0, 1'b0);
    chk("R7 set", {28'd0, match}, 32'd1);
    build(2'd0, 16, 8'h09);
    exp_m = {3'd0, ref_crc(16, 0, 31'h0000_FFFF) == crc_a};
    send(16, 1'b1, 1'b0, 1'b0);
    chk("R7 held", {28'd0, match}, 32'd1);
    clear_status();
    chk("R7 cleared", {28'd0, match}, 32'd0);
    build(2'd0, 16, 8'h03);
    send(16, 1'b1, 1'b0, 1'b1);
    chk("R7 set over clear", {28'd0, match}, 32'd1);

    // R10 back-to-back frames, no idle beat
    build(2'd1, 14, 8'h47);
    crc_b = ref_crc(14, 1, 31'h0000_003F);
    build(2'd0, 10, 8'h21);
    crc_a = ref_crc(10, 0, 31'h7FFF_FFFF);
    b_ofs[0] = 8'd0; b_mask[0] = 31'h7FFF_FFFF; b_cmd[0] = 4'h1; b_crc[0] = crc_a;
    b_ofs[1] = 8'd1; b_mask[1] = 31'h0000_003F; b_cmd[1] = 4'h9; b_crc[1] = crc_b;
    clear_status();
    send(10, 1'b1, 1'b1, 1'b0);
    build(2'd1, 14, 8'h47);
    send(14, 1'b1, 1'b0, 1'b0);
    chk("R10 both frames matched", {28'd0, match}, 32'd3);
    chk("R10 wake on second", {31'd0, wake}, 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule